// File: doc/BRIEF.md
# Integer to Half-Precision Widening Converter

This block turns packed integer lanes into IEEE binary16 values. A source word made of `GROUPS` 32-bit groups is presented together with a two-bit mode. The mode selects whether the source holds bytes or halfwords, and whether those are read as signed or unsigned. When the source holds halfwords, each 16-bit lane produces one half-precision lane in the same position of the first result. The second result is then zero.

When the source holds bytes, the result is twice as wide as the source, so it is spread over two result words. Within each 32-bit group, the two lower bytes land in the first result and the two upper bytes land in the second. Both pairs keep their relative order and sit in the group's two half-precision lanes.

Integers that need more than 11 significant bits are rounded to nearest with ties to even. The exponent is not scaled. A magnitude that rounds past the largest finite value becomes infinity. A single flag reports whether any converted lane lost bits. Results are registered, and `out_valid` marks them one cycle after `in_valid`.

Top module: `int2hf_widen`

## Requirements
- R1: With `mode[1]`=1 (halfword source), source bits [16i+15:16i] convert into `res_first` bits [16i+15:16i], and `res_second` is all zero.
- R2: With `mode[1]`=0 (byte source), bytes 4g and 4g+1 convert into `res_first` half lanes 2g and 2g+1, and bytes 4g+2 and 4g+3 convert into `res_second` half lanes 2g and 2g+1.
- R3: A magnitude of 2048 or less converts exactly. A larger one keeps 11 significant bits, rounded to nearest with ties to even, and carries into the exponent when the rounding overflows the significand.
- R4: A magnitude of 65520 or more becomes 16'h7C00 (positive infinity) when positive. A magnitude from 65505 to 65519 becomes 16'h7BFF. No lane ever produces a NaN pattern.
- R5: An integer zero converts to 16'h0000.
- R6: `mode[0]`=1 reads lanes as two's complement and `mode[0]`=0 as unsigned. A negative value gives sign bit 15 set over the encoding of its absolute value. Byte 8'hFF gives 16'hBC00 when signed and 16'h5BF8 when unsigned, and halfword 16'h8000 signed gives 16'hF800.
- R7: `inexact` is the OR, over all converted lanes, of "the discarded significand bits were nonzero". It is therefore never set in byte modes.
- R8: Results and `inexact` update on the clock edge that samples `in_valid`=1, with `out_valid`=1 in the following cycle. While `in_valid`=0 they hold and `out_valid` is 0.
- R9: Synchronous active-high `rst` clears both results, `inexact` and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Source and mode are valid this cycle |
| mode | input | 2 | Bit 1: halfword source; bit 0: signed |
| src | input | 32*GROUPS | Packed integer source lanes |
| out_valid | output | 1 | Results were loaded on the last edge |
| res_first | output | 32*GROUPS | First half-precision result word |
| res_second | output | 32*GROUPS | Second result word (byte modes only) |
| inexact | output | 1 | Some converted lane was rounded |

## Verification
Within a single lane, the rounding increment and the overflow to infinity can occur together. An unsigned halfword of 65520 or 65535 rounds its significand up, the rounding carries into the exponent, and that carry pushes the exponent to the reserved value. The bench drives such lanes next to exact and near-limit lanes (65519, 65505, 2048, 2049) in the same word. It judges each lane bit-exactly against a bench-side reference, and checks that the combined inexact flag reflects only the lanes that lost bits. Randomly mixed words in all four modes repeat this coincidence across lane positions.

// File: rtl/int2hf_pkg.sv
package int2hf_pkg;

    localparam int MAG_W    = 16;
    localparam int MAN_W    = 10;
    localparam int EXP_W    = 5;
    localparam int EXP_BIAS = 15;
    localparam int HF_W     = 1 + EXP_W + MAN_W;

    typedef enum logic [1:0] {
        CVT_UBYTE = 2'b00,
        CVT_SBYTE = 2'b01,
        CVT_UHALF = 2'b10,
        CVT_SHALF = 2'b11
    } cvt_mode_e;

    typedef struct packed {
        logic             neg;
        logic [MAG_W-1:0] mag;
    } int_operand_t;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] expo;
        logic [MAN_W-1:0] man;
    } half_t;

    function automatic logic is_half_mode(cvt_mode_e m);
        return m[1];
    endfunction

    function automatic logic is_signed_mode(cvt_mode_e m);
        return m[0];
    endfunction

    // Sign/magnitude split of a byte or halfword lane.
    function automatic int_operand_t make_operand(logic [15:0] raw, logic sgn, logic byte_lane);
        logic signed [16:0] v;
        logic signed [16:0] av;
        int_operand_t       o;
        if (byte_lane)
            v = sgn ? {{9{raw[7]}}, raw[7:0]} : {9'b0, raw[7:0]};
        else
            v = sgn ? {raw[15], raw} : {1'b0, raw};
        av    = v[16] ? -v : v;
        o.neg = v[16];
        o.mag = av[15:0];
        return o;
    endfunction

endpackage

// File: rtl/int2hf_lzd.sv
module int2hf_lzd #(
    parameter int W = 16
) (
    input  logic [W-1:0]         vec,
    output logic [$clog2(W)-1:0] pos,
    output logic                 found
);
    localparam int PW = $clog2(W);

    always_comb begin
        pos   = '0;
        found = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                pos   = PW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/int2hf_lane.sv
module int2hf_lane
    import int2hf_pkg::*;
(
    input  int_operand_t op,
    output half_t        res,
    output logic         inexact
);
    localparam int PW   = $clog2(MAG_W);
    localparam int DROP = MAG_W - 1 - MAN_W;

    logic [PW-1:0]    msb;
    logic             nz;
    logic [MAG_W-1:0] norm;
    logic [MAN_W:0]   sig;
    logic             guard, sticky, round_up;
    logic [MAN_W+1:0] sig_r;
    logic             carry;
    logic [EXP_W:0]   exp_pre;

    int2hf_lzd #(.W(MAG_W)) u_lzd (
        .vec  (op.mag),
        .pos  (msb),
        .found(nz)
    );

    always_comb begin
        norm     = op.mag << (PW'(MAG_W - 1) - msb);
        sig      = norm[MAG_W-1 -: MAN_W+1];
        guard    = norm[DROP-1];
        sticky   = |norm[DROP-2:0];
        round_up = guard & (sticky | sig[0]);
        sig_r    = {1'b0, sig} + {{(MAN_W+1){1'b0}}, round_up};
        carry    = sig_r[MAN_W+1];
        exp_pre  = {{(EXP_W+1-PW){1'b0}}, msb} + (EXP_W+1)'(EXP_BIAS)
                   + {{EXP_W{1'b0}}, carry};

        res      = '0;
        inexact  = 1'b0;
        if (nz) begin
            res.sign = op.neg;
            inexact  = guard | sticky;
            if (exp_pre >= (EXP_W+1)'((1 << EXP_W) - 1)) begin
                res.expo = '1;
                res.man  = '0;
            end else begin
                res.expo = exp_pre[EXP_W-1:0];
                res.man  = carry ? sig_r[MAN_W:1] : sig_r[MAN_W-1:0];
            end
        end
    end

    always_comb begin
        // R4
        no_nan_chk: assert (!(res.expo == '1 && res.man != '0));
        // R3
        exact_small_chk: assert (!(inexact && op.mag <= 16'd2048));
    end
endmodule

// File: rtl/int2hf_operand_mux.sv
module int2hf_operand_mux
    import int2hf_pkg::*;
#(
    parameter int GROUPS = 4
) (
    input  logic [32*GROUPS-1:0]           src,
    input  cvt_mode_e                      mode,
    output int_operand_t [2*GROUPS-1:0]    ops_first,
    output int_operand_t [2*GROUPS-1:0]    ops_second
);
    localparam int HLANES = 2 * GROUPS;

    logic half_sel, sgn;
    assign half_sel = is_half_mode(mode);
    assign sgn      = is_signed_mode(mode);

    for (genvar j = 0; j < HLANES; j++) begin : g_lane
        localparam int B_FIRST  = 4 * (j / 2) + (j % 2);
        localparam int B_SECOND = B_FIRST + 2;

        assign ops_first[j] = half_sel
            ? make_operand(src[16*j +: 16], sgn, 1'b0)
            : make_operand({8'b0, src[8*B_FIRST +: 8]}, sgn, 1'b1);

        assign ops_second[j] = half_sel
            ? int_operand_t'('0)
            : make_operand({8'b0, src[8*B_SECOND +: 8]}, sgn, 1'b1);
    end
endmodule

// File: rtl/int2hf_widen.sv
module int2hf_widen
    import int2hf_pkg::*;
#(
    parameter int GROUPS = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [1:0]             mode,
    input  logic [32*GROUPS-1:0]   src,
    output logic                   out_valid,
    output logic [32*GROUPS-1:0]   res_first,
    output logic [32*GROUPS-1:0]   res_second,
    output logic                   inexact
);
    localparam int HLANES = 2 * GROUPS;
    localparam int W      = 32 * GROUPS;

    int_operand_t [HLANES-1:0] ops_first, ops_second;
    half_t        [HLANES-1:0] hf_first, hf_second;
    logic         [HLANES-1:0] ix_first, ix_second;

    int2hf_operand_mux #(.GROUPS(GROUPS)) u_mux (
        .src       (src),
        .mode      (cvt_mode_e'(mode)),
        .ops_first (ops_first),
        .ops_second(ops_second)
    );

    for (genvar j = 0; j < HLANES; j++) begin : g_cvt
        int2hf_lane u_first (
            .op     (ops_first[j]),
            .res    (hf_first[j]),
            .inexact(ix_first[j])
        );
        int2hf_lane u_second (
            .op     (ops_second[j]),
            .res    (hf_second[j]),
            .inexact(ix_second[j])
        );
    end

    logic [W-1:0] first_d, second_d;
    logic         inexact_d;

    always_comb begin
        first_d   = hf_first;
        second_d  = hf_second;
        inexact_d = (|ix_first) | (|ix_second);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            res_first  <= '0;
            res_second <= '0;
            inexact    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_first  <= first_d;
                res_second <= second_d;
                inexact    <= inexact_d;
            end
        end
    end

    // R1
    half_second_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode[1]) |=> (res_second == '0));
    // R7
    byte_exact_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mode[1]) |=> !inexact);
    // R5
    zero_in_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && src == '0) |=> (res_first == '0 && res_second == '0 && !inexact));
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(res_first) && $stable(res_second) && $stable(inexact) && !out_valid));
endmodule

// File: tb/int2hf_widen_test.sv
module int2hf_widen_test;
    localparam int GROUPS = 4;
    localparam int W      = 32 * GROUPS;
    localparam int HL     = 2 * GROUPS;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic [W-1:0] src = '0;
    logic         out_valid;
    logic [W-1:0] res_first, res_second;
    logic         inexact;

    int checks = 0;
    int errors = 0;

    logic [W-1:0] exp_first, exp_second;
    logic         exp_ix;

    int2hf_widen #(.GROUPS(GROUPS)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .src(src),
        .out_valid(out_valid), .res_first(res_first), .res_second(res_second),
        .inexact(inexact)
    );

    always #5 clk = ~clk;

    // Reference: returns {inexact, binary16}
    function automatic logic [16:0] ref_hf(int v);
        int m, e, sh, kept, rem, halfv;
        logic s;
        s = (v < 0);
        m = s ? -v : v;
        if (m == 0) return 17'd0;
        e = 0;
        while ((m >> (e + 1)) != 0) e++;
        if (e <= 10) return {1'b0, s, 5'(e + 15), 10'((m << (10 - e)) & 1023)};
        sh    = e - 10;
        kept  = m >> sh;
        rem   = m - (kept << sh);
        halfv = 1 << (sh - 1);
        if (rem > halfv || (rem == halfv && (kept % 2) == 1)) kept++;
        if (kept == 2048) begin kept = 1024; e++; end
        if (e + 15 >= 31) return {rem != 0, s, 5'd31, 10'd0};
        return {rem != 0, s, 5'(e + 15), 10'(kept - 1024)};
    endfunction

    task automatic compute_expected(logic [1:0] m, logic [W-1:0] s);
        logic [16:0] r;
        int v;
        exp_first = '0; exp_second = '0; exp_ix = 1'b0;
        for (int j = 0; j < HL; j++) begin
            if (m[1]) begin
                v = m[0] ? int'($signed(s[16*j +: 16])) : int'(s[16*j +: 16]);
                r = ref_hf(v);
                exp_first[16*j +: 16] = r[15:0];
                exp_ix |= r[16];
            end else begin
                v = m[0] ? int'($signed(s[8*(4*(j/2)+(j%2)) +: 8])) : int'(s[8*(4*(j/2)+(j%2)) +: 8]);
                r = ref_hf(v);
                exp_first[16*j +: 16] = r[15:0];
                exp_ix |= r[16];
                v = m[0] ? int'($signed(s[8*(4*(j/2)+(j%2)+2) +: 8])) : int'(s[8*(4*(j/2)+(j%2)+2) +: 8]);
                r = ref_hf(v);
                exp_second[16*j +: 16] = r[15:0];
                exp_ix |= r[16];
            end
        end
    endtask

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic apply(logic [1:0] m, logic [W-1:0] s);
        @(negedge clk);
        mode = m; src = s; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 out_valid", W'(out_valid), W'(1));
    endtask

    task automatic apply_and_check(logic [1:0] m, logic [W-1:0] s);
        apply(m, s);
        compute_expected(m, s);
        chk(m[1] ? "R1 first" : "R2 first", res_first, exp_first);
        chk(m[1] ? "R1 second" : "R2 second", res_second, exp_second);
        chk("R7 inexact", W'(inexact), W'(exp_ix));
    endtask

    function automatic logic [W-1:0] rand_word();
        logic [W-1:0] w;
        for (int k = 0; k < GROUPS; k++) w[32*k +: 32] = $urandom();
        return w;
    endfunction

    initial begin
        #1_000_000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] s, held_a, held_b;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk("R9 first", res_first, '0);
        chk("R9 second", res_second, '0);
        chk("R9 flags", W'({out_valid, inexact}), '0);

        // R4 near-limit and overflow lanes, R3 2048/2049
        s = '0;
        s[15:0]   = 16'd65520;
        s[31:16]  = 16'd65519;
        s[47:32]  = 16'd65505;
        s[63:48]  = 16'd2048;
        s[79:64]  = 16'd65535;
        s[95:80]  = 16'd1;
        s[111:96] = 16'd2049;
        s[127:112]= 16'd2051;
        apply_and_check(2'b10, s);
        chk("R4 inf", W'(res_first[15:0]), W'(16'h7C00));
        chk("R4 max finite", W'(res_first[31:16]), W'(16'h7BFF));
        chk("R4 65505", W'(res_first[47:32]), W'(16'h7BFF));
        chk("R3 2049 ties even", W'(res_first[111:96]), W'(16'h6800));
        chk("R3 2051 ties even up", W'(res_first[127:112]), W'(16'h6802));

        // R3 exact only: no inexact
        s = '0;
        s[15:0] = 16'd2048; s[31:16] = 16'd1000; s[47:32] = 16'd4096;
        apply_and_check(2'b10, s);
        chk("R7 exact word", W'(inexact), W'(0));

        // R6 signed halfword -32768 and -1
        s = '0;
        s[15:0] = 16'h8000; s[31:16] = 16'hFFFF;
        apply_and_check(2'b11, s);
        chk("R6 -32768", W'(res_first[15:0]), W'(16'hF800));
        chk("R6 -1 half", W'(res_first[31:16]), W'(16'hBC00));

        // R6 byte 0xFF signed and unsigned
        s = {GROUPS{32'hFFFF_FFFF}};
        apply_and_check(2'b01, s);
        chk("R6 sbyte FF", W'(res_first[15:0]), W'(16'hBC00));
        apply_and_check(2'b00, s);
        chk("R6 ubyte FF", W'(res_second[15:0]), W'(16'h5BF8));

        // R2 byte ordering
        s = '0;
        s[31:0] = 32'h04_03_02_01;
        apply_and_check(2'b00, s);
        chk("R2 byte0", W'(res_first[15:0]), W'(16'h3C00));
        chk("R2 byte1", W'(res_first[31:16]), W'(16'h4000));
        chk("R2 byte2", W'(res_second[15:0]), W'(16'h4200));
        chk("R2 byte3", W'(res_second[31:16]), W'(16'h4400));

        // R5 zero in every mode
        for (int m = 0; m < 4; m++) begin
            apply_and_check(2'(m), '0);
            chk("R5 zero", res_first | res_second, '0);
        end

        // R8 hold while in_valid low
        apply_and_check(2'b10, rand_word());
        held_a = res_first; held_b = res_second;
        @(negedge clk);
        src = rand_word(); mode = 2'b01;
        @(negedge clk);
        chk("R8 hold first", res_first, held_a);
        chk("R8 hold second", res_second, held_b);
        chk("R8 out_valid low", W'(out_valid), '0);

        // random mix, all modes
        for (int n = 0; n < 400; n++) begin
            s = rand_word();
            if (n % 5 == 0) s[15:0] = 16'hFFF0 + 16'($urandom_range(0, 15));
            apply_and_check(2'($urandom_range(0, 3)), s);
        end

        // R9 reset clears after activity
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9 after reset", res_first | res_second, '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule